// File: doc/BRIEF.md
# Graphics Masked Write Datapath

This block forms the write-data path for a graphics memory whose words are 32 bits wide. It keeps two internal registers: a color register and a persistent per-bit write mask. Each write command becomes one registered write beat for the array. The beat carries a column base address, a column-enable vector covering an aligned group of eight columns, a per-bit write-enable vector, and the write data.

The block merges three kinds of masking into one beat. The byte-lane masks apply to the beat in the clock in which they are sampled. The bit mask applies whenever the special-function input is high. In block mode, the color register is written into any subset of eight adjacent columns in a single cycle. When the special-function input is low, writes are plain single-column writes of the data bus. In that case the color register and the bit mask have no effect.

Top module: `gfx_wr_path`

## Requirements
- R1: After reset, all outputs are 0, the bit mask is all ones and the color register is 0. A block write issued right after reset therefore enables all 32 bits and writes data 0.
- R2: A plain write beat writes `dq_i` to one column and ignores the bit mask. A plain write is `cmd_i`=1, or `cmd_i`=2 with `dsf_i`=0. For it, `col_en_o` is one-hot at bit `col_i[2:0]`, `col_base_o` is `col_i` with its three low bits cleared, and `wdata_o` is `dq_i`.
- R3: A masked single write (`cmd_i`=1, `dsf_i`=1) behaves like R2, except that `bit_we_o` is also ANDed with the bit mask.
- R4: A block write (`cmd_i`=2, `dsf_i`=1) sets `col_en_o` to `dq_i[7:0]` (1 = write that column) and `wdata_o` to the color register. `bit_we_o` is the byte-lane enables ANDed with the bit mask, and the three low bits of `col_base_o` are 0 whatever `col_i[2:0]` holds.
- R5: On any write, `dqm_i[k]`=1 clears `bit_we_o[8k+7:8k]` for that beat only.
- R6: A load (`cmd_i`=3) writes the bit mask from `dq_i` when `dsf_i`=0, and the color register when `dsf_i`=1. It produces no write beat, and `dqm_i` has no effect on what is loaded.
- R7: The bit mask and the color register hold their values across any number of write and idle cycles until the next load.
- R8: An idle cycle (`cmd_i`=0) yields `we_o`=0, `col_en_o`=0 and `bit_we_o`=0.
- R9: Every write beat appears on the outputs exactly one clock after its command is sampled. A loaded register value is used by a write issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Decoded command: 0 idle, 1 write, 2 block write, 3 register load |
| dsf_i | input | 1 | Special-function select |
| col_i | input | 8 | Column address |
| dq_i | input | 32 | Data bus (block column selects in bits 7:0) |
| dqm_i | input | 4 | Byte-lane write masks, bit k masks lane k |
| we_o | output | 1 | Write beat valid |
| col_base_o | output | 8 | Aligned base column of the group of eight |
| col_en_o | output | 8 | Column enables within the group |
| bit_we_o | output | 32 | Per-bit write enables |
| wdata_o | output | 32 | Write data |

## Verification
All write-beat outputs come from one register stage, so each result is due at the first rising edge after its command is sampled. The bench drives inputs on the falling edge and compares the outputs on the next falling edge, which is half a cycle after the result becomes valid and before the following command has any effect. A new register value must show up in the write issued in the next cycle, and load-then-write pairs are placed back to back to check this. The array contents are applied from the outputs into a 256-column model and compared against an independent read-modify-write reference at fixed points.

// File: rtl/gfx_wr_pkg.sv
package gfx_wr_pkg;
  localparam int DATA_W   = 32;
  localparam int LANE_W   = 8;
  localparam int BLK_COLS = 8;
  localparam int COL_W    = 8;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_BLOCK = 2'd2,
    CMD_LOAD  = 2'd3
  } cmd_e;
endpackage

// File: rtl/gfx_wr_regs.sv
module gfx_wr_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sel_color_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] color_o,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] color_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      color_q <= '0;
      mask_q  <= '1;
    end else if (load_i) begin
      if (sel_color_i) color_q <= data_i;
      else             mask_q  <= data_i;
    end
  end

  assign color_o = color_q;
  assign mask_o  = mask_q;

  // R6
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !sel_color_i) |=> (mask_q == $past(data_i)));
  // R6
  color_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && sel_color_i) |=> (color_q == $past(data_i)));
  // R7
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && !sel_color_i) |=> $stable(mask_q));
  // R7
  color_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && sel_color_i) |=> $stable(color_q));
endmodule

// File: rtl/gfx_wr_colsel.sv
module gfx_wr_colsel #(
  parameter int BLK_COLS = 8,
  localparam int BLK_AW  = $clog2(BLK_COLS)
) (
  input  logic                blk_i,
  input  logic [BLK_AW-1:0]   col_lo_i,
  input  logic [BLK_COLS-1:0] sel_i,
  output logic [BLK_COLS-1:0] col_en_o
);
  for (genvar c = 0; c < BLK_COLS; c++) begin : g_col
    assign col_en_o[c] = blk_i ? sel_i[c] : (col_lo_i == BLK_AW'(c));
  end
endmodule

// File: rtl/gfx_wr_biten.sv
module gfx_wr_biten #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [LANES-1:0]  dqm_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              use_mask_i,
  output logic [DATA_W-1:0] bit_we_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] lane_mask;
    assign lane_mask = use_mask_i ? mask_i[k*LANE_W +: LANE_W] : '1;
    assign bit_we_o[k*LANE_W +: LANE_W] = dqm_i[k] ? '0 : lane_mask;
  end
endmodule

// File: rtl/gfx_wr_path.sv
module gfx_wr_path
  import gfx_wr_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int LW  = LANE_W,
  parameter int NC  = BLK_COLS,
  parameter int CW  = COL_W,
  localparam int NL = DW / LW,
  localparam int AW = $clog2(NC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cmd_i,
  input  logic          dsf_i,
  input  logic [CW-1:0] col_i,
  input  logic [DW-1:0] dq_i,
  input  logic [NL-1:0] dqm_i,
  output logic          we_o,
  output logic [CW-1:0] col_base_o,
  output logic [NC-1:0] col_en_o,
  output logic [DW-1:0] bit_we_o,
  output logic [DW-1:0] wdata_o
);
  cmd_e cmd;
  logic is_wr, is_blk, use_mask, is_load;
  logic [DW-1:0] color, mask, bit_we_d;
  logic [NC-1:0] col_en_d;

  assign cmd      = cmd_e'(cmd_i);
  assign is_wr    = (cmd == CMD_WRITE) || (cmd == CMD_BLOCK);
  assign is_blk   = (cmd == CMD_BLOCK) && dsf_i;
  assign use_mask = is_wr && dsf_i;
  assign is_load  = (cmd == CMD_LOAD);

  gfx_wr_regs #(.DATA_W(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (is_load),
    .sel_color_i (dsf_i),
    .data_i      (dq_i),
    .color_o     (color),
    .mask_o      (mask)
  );

  gfx_wr_colsel #(.BLK_COLS(NC)) u_colsel (
    .blk_i    (is_blk),
    .col_lo_i (col_i[AW-1:0]),
    .sel_i    (dq_i[NC-1:0]),
    .col_en_o (col_en_d)
  );

  gfx_wr_biten #(.DATA_W(DW), .LANE_W(LW)) u_biten (
    .dqm_i      (dqm_i),
    .mask_i     (mask),
    .use_mask_i (use_mask),
    .bit_we_o   (bit_we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o       <= 1'b0;
      col_base_o <= '0;
      col_en_o   <= '0;
      bit_we_o   <= '0;
      wdata_o    <= '0;
    end else if (is_wr) begin
      we_o       <= 1'b1;
      col_base_o <= {col_i[CW-1:AW], {AW{1'b0}}};
      col_en_o   <= col_en_d;
      bit_we_o   <= bit_we_d;
      wdata_o    <= is_blk ? color : dq_i;
    end else begin
      we_o       <= 1'b0;
      col_en_o   <= '0;
      bit_we_o   <= '0;
      wdata_o    <= '0;
    end
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_i == 2'd1 || cmd_i == 2'd2) |=> (!we_o && col_en_o == '0 && bit_we_o == '0));
  // R2
  single_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1 || (cmd_i == 2'd2 && !dsf_i)) |=> ($onehot(col_en_o) && wdata_o == $past(dq_i)));
  // R4
  blk_cols_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd2 && dsf_i) |=> (col_en_o == $past(dq_i[NC-1:0]) && col_base_o[AW-1:0] == '0));
  // R9
  beat_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1 || cmd_i == 2'd2) |=> we_o);

  for (genvar k = 0; k < NL; k++) begin : g_lane_chk
    // R5
    lane_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cmd_i == 2'd1 || cmd_i == 2'd2) && dqm_i[k]) |=> (bit_we_o[k*LW +: LW] == '0));
  end
endmodule

// File: tb/sim_gfx_wr_path.sv
module sim_gfx_wr_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic        dsf = 1'b0;
  logic [7:0]  col = '0;
  logic [31:0] dq = '0;
  logic [3:0]  dqm = '0;
  logic        we;
  logic [7:0]  col_base, col_en;
  logic [31:0] bit_we, wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_mask, m_color;
  logic [31:0] ref_arr [256];
  logic [31:0] dut_arr [256];

  always #10 clk = ~clk;

  gfx_wr_path u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .dsf_i(dsf), .col_i(col),
    .dq_i(dq), .dqm_i(dqm), .we_o(we), .col_base_o(col_base),
    .col_en_o(col_en), .bit_we_o(bit_we), .wdata_o(wdata)
  );

  function automatic logic [31:0] lanes(input logic [3:0] m);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = m[k] ? 8'h00 : 8'hFF;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one command: drive at negedge, compare beat at next negedge
  task automatic step(input logic [1:0] c, input logic s, input logic [7:0] a,
                      input logic [31:0] d, input logic [3:0] m);
    logic        e_we;
    logic [7:0]  e_en, e_base;
    logic [31:0] e_bwe, e_dat;
    string req;
    cmd = c; dsf = s; col = a; dq = d; dqm = m;
    e_we = (c == 2'd1 || c == 2'd2);
    e_base = {a[7:3], 3'b000};
    if (!e_we) begin
      req = (c == 2'd3) ? "R6" : "R8";
      e_en = '0; e_bwe = '0; e_dat = '0;
    end else if (c == 2'd2 && s) begin
      req = "R4";
      e_en = d[7:0]; e_bwe = lanes(m) & m_mask; e_dat = m_color;
    end else begin
      req = s ? "R3" : "R2";
      e_en = 8'd1 << a[2:0];
      e_bwe = s ? (lanes(m) & m_mask) : lanes(m);
      e_dat = d;
    end
    if (c == 2'd3) begin
      if (s) m_color = d; else m_mask = d;
    end
    @(negedge clk);
    chk({req, "/R9 we"}, {31'd0, we}, {31'd0, e_we});
    chk({req, " col_en"}, {24'd0, col_en}, {24'd0, e_en});
    chk({req, " bit_we"}, bit_we, e_bwe);
    if (e_we) begin
      chk({req, " wdata"}, wdata, e_dat);
      chk({req, " base"}, {24'd0, col_base}, {24'd0, e_base});
      for (int j = 0; j < 8; j++) begin
        if (col_en[j])
          dut_arr[col_base + 8'(j)] = (dut_arr[col_base + 8'(j)] & ~bit_we) | (wdata & bit_we);
        if (e_en[j])
          ref_arr[e_base + 8'(j)] = (ref_arr[e_base + 8'(j)] & ~e_bwe) | (e_dat & e_bwe);
      end
    end
  endtask

  task automatic cmp_arrays();
    int bad = 0;
    for (int i = 0; i < 256; i++) if (dut_arr[i] !== ref_arr[i]) bad++;
    chk("R7 array", 32'(bad), 32'd0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_mask = '1; m_color = '0;
    for (int i = 0; i < 256; i++) begin
      ref_arr[i] = 32'h5A5A_0000 + 32'(i);
      dut_arr[i] = ref_arr[i];
    end
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 we", {31'd0, we}, 32'd0);
    chk("R1 bit_we", bit_we, 32'd0);
    chk("R1 col_en", {24'd0, col_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 block write with reset color/mask
    step(2'd2, 1'b1, 8'h13, 32'h0000_00FF, 4'h0);
    // R6 load mask with dqm set (ignored), then R9 immediate use
    step(2'd3, 1'b0, 8'h00, 32'hF0F0_00FF, 4'hF);
    step(2'd1, 1'b1, 8'h25, 32'hDEAD_BEEF, 4'h0);
    // R2 plain write ignores mask
    step(2'd1, 1'b0, 8'h26, 32'h1234_5678, 4'h0);
    step(2'd2, 1'b0, 8'h27, 32'hCAFE_F00D, 4'h2);
    // R6 color load then R4 block write, low col bits ignored
    step(2'd3, 1'b1, 8'h00, 32'hA5C3_3C5A, 4'hF);
    step(2'd2, 1'b1, 8'h47, 32'h0000_00A5, 4'h0);
    // R4 empty select, R5 dqm lanes
    step(2'd2, 1'b1, 8'h40, 32'h0000_0000, 4'h0);
    step(2'd1, 1'b1, 8'h50, 32'hFFFF_FFFF, 4'h5);
    // R8 idle, R7 mask persists
    for (int i = 0; i < 5; i++) step(2'd0, 1'b1, 8'hFF, 32'hFFFF_FFFF, 4'h0);
    step(2'd2, 1'b1, 8'h88, 32'h0000_00FF, 4'h0);
    cmp_arrays();
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] c;
      c = 2'($urandom_range(0, 3));
      if (c == 2'd3 && $urandom_range(0, 3) != 0) c = 2'd1;
      step(c, 1'($urandom), 8'($urandom), $urandom, 4'($urandom));
      if (n % 500 == 499) cmp_arrays();
    end
    cmp_arrays();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule